// File: doc/BRIEF.md
# Streaming Priority Bus Arbiter

This block decides which requester owns a shared address bus. One requester is the processor core. The others are I/O masters. Each I/O master presents a 2-bit priority with its request. The core has no per-request priority. Its level comes from a configuration input, and that level applies to every core request. The grant output is registered and either one-hot or all zero. It moves only on the cycle after the bus signals a finished address tenure with a one-cycle accept strobe, or when no one holds the bus.

A winner may keep the bus for several tenures in a row, called a run. The maximum run length is a 2-bit configuration field plus one, so the value 3 allows four tenures. A run ends when any of the following happens:
- the limit is reached;
- the owner drops its request;
- a waiting request with a strictly higher priority than the owner's shows up at an accept.

The core may run only while a separate enable input is set. When the enable is clear, each core grant covers a single tenure. When the bus is free or a run ends, the highest pending priority wins. Ties go round-robin, starting just after the most recently granted requester.

Top module: `spa_arbiter`

## Requirements
- R1: While the synchronous reset is high, and on the first cycle after it, no grant bit is set.
- R2: The grant vector always has at most one bit set. Bit 0 is the core. Bit k+1 is I/O master k.
- R3: When no grant is active and at least one request is pending, the highest-priority pending requester is granted on the next cycle.
- R4: Among requesters of equal top priority, the winner is the first one found going upward, with wrap-around, from the index after the last granted requester. After reset, the search starts at index 0.
- R5: Every core request carries the priority given by the core-priority configuration input. At value 0, the core never breaks into a run held by an I/O master of level 0 or above.
- R6: At an accept, a run is broken only by a pending request whose priority is strictly greater than the owner's current priority. Equal priority never preempts.
- R7: A run lasts at most (run-length field + 1) accepted tenures. Once the limit is reached, arbitration is redone on the next cycle.
- R8: With the core streaming enable low, every accept during a core grant forces re-arbitration. With it high, the core streams like any other requester.
- R9: If the owner's request is low at an accept, the run ends. The next grant goes to the arbitration winner, or to no one if nothing is pending.
- R10: While a grant is active and accept is low, the grant does not change.
- R11: The run counter restarts from zero at every new grant, including when the same requester is granted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| core_req | input | 1 | Core requests the bus |
| io_req | input | NUM_IO | Request per I/O master |
| io_prio | input | NUM_IO*PRIO_W | Packed priorities; master k uses bits [k*PRIO_W +: PRIO_W] |
| accept | input | 1 | One-cycle strobe: current address tenure completed |
| cfg_core_prio | input | PRIO_W | Priority applied to all core requests |
| cfg_run_len | input | CNT_W | Maximum run length minus one |
| cfg_core_stream_en | input | 1 | Allows the core to stream |
| grant | output | NUM_IO+1 | Registered one-hot grant, bit 0 = core |

## Verification
The embedded properties assume that accept is pulsed only while a grant is active. They also assume that configuration inputs may change at any clock edge. Because of that, no property relies on configuration staying fixed across a run. The bench drives accept only when its own reference state shows an owner. It then sweeps all 32 combinations of run length, core priority and streaming enable, using pseudo-random requests and priorities, and changes configuration only at negative clock edges.

// File: rtl/spa_pkg.sv
package spa_pkg;
    // Default widths shared by the arbiter and its helpers.
    localparam int unsigned SPA_PRIO_W = 2;
    localparam int unsigned SPA_CNT_W  = 2;

    // Length of a run in accepted tenures for a given field value.
    function automatic int unsigned spa_run_limit(input int unsigned field,
                                                  input bit          single);
        return single ? 1 : field + 1;
    endfunction
endpackage

// File: rtl/spa_prio_max.sv
module spa_prio_max #(
    parameter int unsigned N      = 4,
    parameter int unsigned PRIO_W = 2
) (
    input  logic [N-1:0]        req,
    input  logic [N*PRIO_W-1:0] prio,
    output logic [PRIO_W-1:0]   max_prio,
    output logic [N-1:0]        max_mask,
    output logic                any_req
);
    always_comb begin
        max_prio = '0;
        any_req  = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any_req = 1'b1;
                if (prio[i*PRIO_W +: PRIO_W] > max_prio) begin
                    max_prio = prio[i*PRIO_W +: PRIO_W];
                end
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_mask
            assign max_mask[g] = req[g] && (prio[g*PRIO_W +: PRIO_W] == max_prio);
        end
    endgenerate
endmodule

// File: rtl/spa_rr_pick.sv
module spa_rr_pick #(
    parameter int unsigned N  = 4,
    parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  cand,
    input  logic [IW-1:0] last_idx,
    output logic [IW-1:0] pick_idx,
    output logic          pick_valid
);
    always_comb begin
        pick_idx   = '0;
        pick_valid = 1'b0;
        for (int k = 1; k <= int'(N); k++) begin
            int idx;
            idx = (int'(last_idx) + k) % int'(N);
            if (!pick_valid && cand[idx]) begin
                pick_valid = 1'b1;
                pick_idx   = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/spa_arbiter.sv
module spa_arbiter
    import spa_pkg::*;
#(
    parameter int unsigned NUM_IO = 3,
    parameter int unsigned PRIO_W = SPA_PRIO_W,
    parameter int unsigned CNT_W  = SPA_CNT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     core_req,
    input  logic [NUM_IO-1:0]        io_req,
    input  logic [NUM_IO*PRIO_W-1:0] io_prio,
    input  logic                     accept,
    input  logic [PRIO_W-1:0]        cfg_core_prio,
    input  logic [CNT_W-1:0]         cfg_run_len,
    input  logic                     cfg_core_stream_en,
    output logic [NUM_IO:0]          grant
);
    localparam int unsigned N     = NUM_IO + 1;
    localparam int unsigned IW    = (N > 1) ? $clog2(N) : 1;
    localparam int unsigned RUN_W = CNT_W + 1;

    typedef struct packed {
        logic [N-1:0]     gnt;
        logic [IW-1:0]    owner;
        logic [IW-1:0]    last;
        logic [RUN_W-1:0] cnt;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [N-1:0]        req_all;
    logic [N*PRIO_W-1:0] prio_all;
    logic [PRIO_W-1:0]   max_prio;
    logic [N-1:0]        max_mask;
    logic                any_req;
    logic [IW-1:0]       win_idx;
    logic                win_valid;
    logic [PRIO_W-1:0]   owner_prio;
    logic                owner_req;
    logic                hi_pending;
    logic [RUN_W-1:0]    run_limit;
    logic [RUN_W-1:0]    cnt_inc;
    logic                keep_run;

    assign req_all  = {io_req, core_req};
    assign prio_all = {io_prio, cfg_core_prio};

    spa_prio_max #(.N(N), .PRIO_W(PRIO_W)) prio_max_i (
        .req      (req_all),
        .prio     (prio_all),
        .max_prio (max_prio),
        .max_mask (max_mask),
        .any_req  (any_req)
    );

    spa_rr_pick #(.N(N), .IW(IW)) rr_pick_i (
        .cand       (max_mask),
        .last_idx   (st_q.last),
        .pick_idx   (win_idx),
        .pick_valid (win_valid)
    );

    always_comb begin
        owner_prio = prio_all[st_q.owner*PRIO_W +: PRIO_W];
        owner_req  = req_all[st_q.owner];
        hi_pending = any_req && (max_prio > owner_prio);
        run_limit  = RUN_W'(spa_run_limit(int'(cfg_run_len),
                            (st_q.owner == '0) && !cfg_core_stream_en));
        cnt_inc    = st_q.cnt + RUN_W'(1);
        keep_run   = owner_req && (cnt_inc < run_limit) && !hi_pending;
    end

    always_comb begin
        st_d = st_q;
        if (st_q.gnt == '0 || (accept && !keep_run)) begin
            st_d.cnt = '0;
            if (win_valid) begin
                st_d.gnt   = N'(1) << win_idx;
                st_d.owner = win_idx;
                st_d.last  = win_idx;
            end else begin
                st_d.gnt = '0;
            end
        end else if (accept) begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.gnt   <= '0;
            st_q.owner <= '0;
            st_q.last  <= IW'(N - 1);
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant = st_q.gnt;

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (grant == '0));

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R3
    idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (grant == '0 && any_req) |=> (grant != '0));

    // R10
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && !accept) |=> $stable(grant));

    // R6
    preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && accept && hi_pending) |=> (grant != $past(grant)));

    // R8
    core_single_chk: assert property (@(posedge clk) disable iff (rst)
        (grant[0] && accept && !cfg_core_stream_en) |=> (st_q.cnt == '0));
endmodule

// File: tb/spa_arbiter_tb_top.sv
`timescale 1ns/1ps
module spa_arbiter_tb_top;
    localparam int NIO = 3;
    localparam int N   = NIO + 1;
    localparam int PW  = 2;
    localparam int CW  = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            core_req = 1'b0;
    logic [NIO-1:0]  io_req = '0;
    logic [NIO*PW-1:0] io_prio = '0;
    logic            accept = 1'b0;
    logic [PW-1:0]   cprio = '0;
    logic [CW-1:0]   runlen = 2'b11;
    logic            en = 1'b1;
    logic [N-1:0]    grant;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference state
    int m_grant = -1;
    int m_cnt   = 0;
    int m_last  = N - 1;

    always #10 clk = ~clk;

    spa_arbiter #(.NUM_IO(NIO), .PRIO_W(PW), .CNT_W(CW)) dut_i (
        .clk                (clk),
        .rst                (rst),
        .core_req           (core_req),
        .io_req             (io_req),
        .io_prio            (io_prio),
        .accept             (accept),
        .cfg_core_prio      (cprio),
        .cfg_run_len        (runlen),
        .cfg_core_stream_en (en),
        .grant              (grant)
    );

    function automatic int prio_of(int i);
        return (i == 0) ? int'(cprio) : int'(io_prio[(i-1)*PW +: PW]);
    endfunction

    function automatic bit req_of(int i);
        return (i == 0) ? core_req : io_req[i-1];
    endfunction

    function automatic int pick();
        int best = -1;
        int bp   = -1;
        for (int k = 1; k <= N; k++) begin
            int idx = (m_last + k) % N;
            if (req_of(idx) && prio_of(idx) > bp) begin
                best = idx;
                bp   = prio_of(idx);
            end
        end
        return best;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_grant = -1;
            m_cnt   = 0;
            m_last  = N - 1;
        end else begin
            int w;
            int lim;
            bit hi;
            if (m_grant < 0) begin
                w = pick();
                if (w >= 0) begin
                    m_grant = w; m_cnt = 0; m_last = w;
                end
            end else if (accept) begin
                lim = (m_grant == 0 && !en) ? 1 : int'(runlen) + 1;
                hi  = 1'b0;
                for (int j = 0; j < N; j++)
                    if (req_of(j) && prio_of(j) > prio_of(m_grant)) hi = 1'b1;
                if (req_of(m_grant) && (m_cnt + 1 < lim) && !hi) begin
                    m_cnt = m_cnt + 1;
                end else begin
                    w = pick();
                    m_grant = w;
                    m_cnt   = 0;
                    if (w >= 0) m_last = w;
                end
            end
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input logic [N-1:0] exp, input string tag);
        n_chk++;
        if (grant !== exp) begin
            n_fail++;
            $display("FAIL %s: grant actual=%b expected=%b", tag, grant, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic acc();
        accept = 1'b1;
        tick();
        accept = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        chk('0, "R1 in reset");
        rst = 1'b0;
        tick();
        chk('0, "R1 after reset");

        // Equal-priority I/O masters outrank core at level 0
        io_prio  = {2'd0, 2'd2, 2'd2};
        io_req   = 3'b011;
        core_req = 1'b1;
        tick();
        chk(4'b0010, "R3 R4 first grant");
        acc(); chk(4'b0010, "R6 R7 run 1");
        acc(); chk(4'b0010, "R6 R7 run 2");
        acc(); chk(4'b0010, "R6 R7 run 3");
        acc(); chk(4'b0100, "R7 R4 limit reached");

        // Strictly higher request appears
        io_prio = {2'd3, 2'd2, 2'd2};
        io_req  = 3'b111;
        tick(); chk(4'b0100, "R10 no accept");
        acc();  chk(4'b1000, "R6 preempt");

        // Owner drops request
        io_req = 3'b100;
        acc(); chk(4'b1000, "R9 owner still requesting");
        io_req = 3'b000;
        acc(); chk(4'b0001, "R9 owner dropped");

        // Core streaming enable and core priority
        io_prio = '0;
        io_req  = 3'b001;
        en      = 1'b0;
        acc(); chk(4'b0010, "R8 core single tenure");
        acc(); chk(4'b0010, "R5 core level 0 cannot preempt");
        cprio = 2'd1;
        acc(); chk(4'b0001, "R5 core level 1 preempts");
        en = 1'b1;
        acc(); chk(4'b0001, "R8 core streams when enabled");

        // Everything idle
        core_req = 1'b0;
        io_req   = 3'b000;
        acc();  chk(4'b0000, "R9 no requester left");
        tick(); chk(4'b0000, "R10 idle");

        // Counter restart on new grant
        cprio    = 2'd0;
        runlen   = 2'd1;
        core_req = 1'b1;
        io_req   = 3'b001;
        tick(); chk(4'b0010, "R4 idle grant after core");
        acc();  chk(4'b0010, "R7 run of two, first");
        acc();  chk(4'b0001, "R7 limit two");
        acc();  chk(4'b0001, "R11 counter restarted");
        acc();  chk(4'b0010, "R7 R11 limit again");

        // Sweep every configuration with pseudo-random traffic
        for (int combo = 0; combo < 32; combo++) begin
            runlen = combo[1:0];
            cprio  = combo[3:2];
            en     = combo[4];
            for (int c = 0; c < 100; c++) begin
                chk((m_grant < 0) ? '0 : (N'(1) << m_grant),
                    "R2 R3 R4 R5 R6 R7 R8 R9 R11 sweep");
                core_req = ($urandom % 4) != 0;
                for (int q = 0; q < NIO; q++) io_req[q] = ($urandom % 4) != 0;
                io_prio = NIO*PW'($urandom);
                accept  = (m_grant >= 0) && ($urandom % 2 == 1);
                tick();
            end
        end
        accept = 1'b0;

        done = 1'b1;
        summary();
        $finish;
    end
endmodule